// File: doc/BRIEF.md
# Power-Good Signal Generator

This block reduces the health of several supply rails to one power-good pin. Each rail supplies an undervoltage flag and an overvoltage flag. The rail counts as good when its undervoltage flag is clear. In window mode the overvoltage flag must also be clear. A per-rail mask selects which rails take part. The combined result can come from the live comparator flags or, in latched mode, from per-rail fault-status bits that logic elsewhere holds and clears.

The combined result passes through a debounce stage that delays only the change to valid. The delay is a number of microsecond ticks, short or long as configured. Loss of validity reaches the output on the next clock. The output stage applies the programmed polarity. It then drives the pin either as push-pull or as open-drain, where the block pulls low or releases the pin through its output enable. A separate active-low interrupt output can also carry the live good status of rail 0.

Top module: `pgood_gen`

## Requirements
- R1: Rail i is good when uv_flag_i[i] is 0, and also ov_flag_i[i] is 0 when config bit 2 (window mode) is 1. With bit 2 at 0 the overvoltage flag has no effect.
- R2: Only rails with rail_mask_i[i]=1 take part. The combined result is good when every included rail is good, and is good when no rail is included.
- R3: With config bit 3 (latched mode) at 1, the combined result uses flt_ok_i[i] (1 = no fault) of the included rails in place of the live flags. The live flags then have no effect on pg_out_o.
- R4: The validity state becomes 1 only after the combined result has been good on TICK_CYCLES*SHORT_TICKS consecutive clock edges when config bit 4 is 0, or on TICK_CYCLES*LONG_TICKS edges when bit 4 is 1.
- R5: When the combined result is not good at a clock edge, the validity state is 0 after that edge.
- R6: A single edge with a non-good result during the count restarts the full debounce time. This includes the edge on which the count would have completed.
- R7: Config bit 0 sets polarity. The output level equals the validity state at 0 and its inverse at 1.
- R8: Config bit 1 sets the drive type. At 0, pg_oe_o=1 and pg_out_o is the output level. At 1, pg_out_o=0 and pg_oe_o is the inverse of the output level.
- R9: int_n_o equals int_src_n_i when config bit 5 is 0. At 1 it equals int_src_n_i AND the live good status of rail 0 (per R1, not masked, not debounced), combinationally.
- R10: While rst_n is low and after it is released, the validity state and the debounce count are cleared. Validity then needs the full debounce time again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag_i | input | N_RAILS | Per-rail undervoltage flag, 1 = under |
| ov_flag_i | input | N_RAILS | Per-rail overvoltage flag, 1 = over |
| rail_mask_i | input | N_RAILS | 1 = rail included in the combined result |
| flt_ok_i | input | N_RAILS | Per-rail latched fault status, 1 = no fault |
| int_src_n_i | input | 1 | Active-low interrupt source |
| cfg_i | input | 6 | bit0 polarity, bit1 open-drain, bit2 window, bit3 latched, bit4 long delay, bit5 rail-0 interrupt merge |
| pg_out_o | output | 1 | Power-good pin level |
| pg_oe_o | output | 1 | Power-good pin output enable |
| int_n_o | output | 1 | Merged active-low interrupt |

## Verification
Two functions can act on the same edge: the debounce count reaching its end, and a rail dropping out. The bench holds a rail good for one edge less than the short delay. It then removes the rail so that the non-good result is sampled on the edge that would have completed the count. It expects the output to stay at the not-valid level, and expects a later full window to be needed before validity. The bench also cuts in on a completed count with a one-edge loss, and expects the not-valid level one edge later.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

   // Configuration word as seen by the block (bit 0 is the LSB)
   typedef struct packed {
      logic int_merge;   // bit 5
      logic long_dly;    // bit 4
      logic latched;     // bit 3
      logic window;      // bit 2
      logic open_drain;  // bit 1
      logic pol_inv;     // bit 0
   } pg_cfg_t;

   localparam int unsigned CFG_W = $bits(pg_cfg_t);

   function automatic pg_cfg_t cfg_decode(input logic [CFG_W-1:0] raw);
      return pg_cfg_t'(raw);
   endfunction

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pgood_rail_eval.sv
module pgood_rail_eval #(
   parameter int unsigned N_RAILS = 4
) (
   input  logic [N_RAILS-1:0] uv_flag,
   input  logic [N_RAILS-1:0] ov_flag,
   input  logic [N_RAILS-1:0] rail_mask,
   input  logic [N_RAILS-1:0] flt_ok,
   input  logic               window,
   input  logic               latched,
   output logic [N_RAILS-1:0] rail_good,
   output logic               raw_ok
);

   logic [N_RAILS-1:0] qual;

   for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
      // Undervoltage always checked; overvoltage only in window mode
      assign rail_good[i] = ~uv_flag[i] & (~window | ~ov_flag[i]);
      // Excluded rails never pull the result down
      assign qual[i] = ~rail_mask[i] | (latched ? flt_ok[i] : rail_good[i]);
   end

   assign raw_ok = &qual;

endmodule

// File: rtl/pgood_debounce.sv
module pgood_debounce #(
   parameter int unsigned TICK_CYCLES = 100,
   parameter int unsigned SHORT_TICKS = 8,
   parameter int unsigned LONG_TICKS  = 11000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_ok,
   input  logic long_dly,
   output logic valid
);
   import pgood_pkg::*;

   localparam int unsigned CNT_W = cnt_width(LONG_TICKS);
   localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_TICKS - 1);
   localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_TICKS - 1);

   if (SHORT_TICKS < 1) begin : g_bad_short
      $error("pgood_debounce: SHORT_TICKS must be at least 1");
   end
   if (LONG_TICKS < SHORT_TICKS) begin : g_bad_long
      $error("pgood_debounce: LONG_TICKS must not be below SHORT_TICKS");
   end
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("pgood_debounce: TICK_CYCLES must be at least 1");
   end

   logic             run;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target_m1;

   // Timebase only runs while a rise is being qualified
   assign run       = raw_ok & ~valid;
   assign target_m1 = long_dly ? LONG_M1 : SHORT_M1;

   if (TICK_CYCLES == 1) begin : g_no_presc
      assign tick = run;
   end else begin : g_presc
      localparam int unsigned PRE_W = cnt_width(TICK_CYCLES - 1);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
      logic [PRE_W-1:0] pre_q;

      assign tick = run & (pre_q == PRE_LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (!run || tick) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         cnt_q <= '0;
      end else if (!raw_ok) begin
         valid <= 1'b0;
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q >= target_m1) begin
            valid <= 1'b1;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pgood_out_stage.sv
module pgood_out_stage (
   input  logic valid,
   input  logic pol_inv,
   input  logic open_drain,
   input  logic int_src_n,
   input  logic int_merge,
   input  logic rail0_good,
   output logic pg_out,
   output logic pg_oe,
   output logic int_n
);

   logic level;

   always_comb begin
      level = valid ^ pol_inv;
      if (open_drain) begin
         pg_out = 1'b0;
         pg_oe  = ~level;
      end else begin
         pg_out = level;
         pg_oe  = 1'b1;
      end
      int_n = int_src_n & ~(int_merge & ~rail0_good);
   end

endmodule

// File: rtl/pgood_gen.sv
module pgood_gen #(
   parameter int unsigned N_RAILS     = 4,
   parameter int unsigned TICK_CYCLES = 100,
   parameter int unsigned SHORT_TICKS = 8,
   parameter int unsigned LONG_TICKS  = 11000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_RAILS-1:0]          uv_flag_i,
   input  logic [N_RAILS-1:0]          ov_flag_i,
   input  logic [N_RAILS-1:0]          rail_mask_i,
   input  logic [N_RAILS-1:0]          flt_ok_i,
   input  logic                        int_src_n_i,
   input  logic [pgood_pkg::CFG_W-1:0] cfg_i,
   output logic                        pg_out_o,
   output logic                        pg_oe_o,
   output logic                        int_n_o
);
   import pgood_pkg::*;

   if (N_RAILS < 1) begin : g_bad_rails
      $error("pgood_gen: N_RAILS must be at least 1");
   end

   pg_cfg_t            cfg;
   logic [N_RAILS-1:0] rail_good;
   logic               raw_ok;
   logic               pg_valid;

   assign cfg = cfg_decode(cfg_i);

   pgood_rail_eval #(.N_RAILS(N_RAILS)) u_eval (
      .uv_flag   (uv_flag_i),
      .ov_flag   (ov_flag_i),
      .rail_mask (rail_mask_i),
      .flt_ok    (flt_ok_i),
      .window    (cfg.window),
      .latched   (cfg.latched),
      .rail_good (rail_good),
      .raw_ok    (raw_ok)
   );

   pgood_debounce #(
      .TICK_CYCLES (TICK_CYCLES),
      .SHORT_TICKS (SHORT_TICKS),
      .LONG_TICKS  (LONG_TICKS)
   ) u_deb (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_ok   (raw_ok),
      .long_dly (cfg.long_dly),
      .valid    (pg_valid)
   );

   pgood_out_stage u_out (
      .valid      (pg_valid),
      .pol_inv    (cfg.pol_inv),
      .open_drain (cfg.open_drain),
      .int_src_n  (int_src_n_i),
      .int_merge  (cfg.int_merge),
      .rail0_good (rail_good[0]),
      .pg_out     (pg_out_o),
      .pg_oe      (pg_oe_o),
      .int_n      (int_n_o)
   );

endmodule

// File: rtl/pgood_chk.sv
module pgood_chk (
   input logic clk,
   input logic rst_n,
   input logic raw_ok,
   input logic valid,
   input logic pol_inv,
   input logic open_drain,
   input logic int_merge,
   input logic rail0_good,
   input logic int_src_n,
   input logic pg_out,
   input logic pg_oe,
   input logic int_n
);

   // R5
   drop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_ok |=> !valid);

   // R4
   rise_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(raw_ok));

   // R10
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !valid);

   // R8
   push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !open_drain |-> (pg_oe && (pg_out == (valid ^ pol_inv))));

   // R8
   open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_drain |-> (!pg_out && (pg_oe == !(valid ^ pol_inv))));

   // R9
   int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !int_src_n |-> !int_n);

   // R9
   int_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_merge && !rail0_good) |-> !int_n);

endmodule

bind pgood_gen pgood_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .raw_ok     (raw_ok),
   .valid      (pg_valid),
   .pol_inv    (cfg_i[0]),
   .open_drain (cfg_i[1]),
   .int_merge  (cfg_i[5]),
   .rail0_good (rail_good[0]),
   .int_src_n  (int_src_n_i),
   .pg_out     (pg_out_o),
   .pg_oe      (pg_oe_o),
   .int_n      (int_n_o)
);

// File: tb/tb_pgood_gen.sv
module tb_pgood_gen;

   localparam int N     = 3;
   localparam int TICK  = 2;
   localparam int SHORT = 8;
   localparam int LONG  = 30;
   localparam int DS    = TICK * SHORT;  // 16 edges
   localparam int DL    = TICK * LONG;   // 60 edges

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] uv = '1, ov = '0, mask = '1, flt = '1;
   logic         int_src_n = 1'b1;
   logic [5:0]   cfg = '0;
   logic         pg_out, pg_oe, int_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pgood_gen #(.N_RAILS(N), .TICK_CYCLES(TICK), .SHORT_TICKS(SHORT),
               .LONG_TICKS(LONG)) dut (
      .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .ov_flag_i(ov),
      .rail_mask_i(mask), .flt_ok_i(flt), .int_src_n_i(int_src_n),
      .cfg_i(cfg), .pg_out_o(pg_out), .pg_oe_o(pg_oe), .int_n_o(int_n));

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Expected pin level for a given validity (push-pull, polarity 0 unless set)
   task automatic chk_valid(input string req, input bit exp_v);
      chk(req, {pg_oe, pg_out}, {1'b1, exp_v ^ cfg[0]});
   endtask

   function automatic bit live_ok(input logic [N-1:0] u, o, m, input bit win);
      bit ok = 1'b1;
      for (int i = 0; i < N; i++)
         if (m[i] && (u[i] || (win && o[i]))) ok = 1'b0;
      return ok;
   endfunction

   function automatic bit latch_ok(input logic [N-1:0] f, m);
      bit ok = 1'b1;
      for (int i = 0; i < N; i++)
         if (m[i] && !f[i]) ok = 1'b0;
      return ok;
   endfunction

   task automatic go_bad();
      @(negedge clk);
      cfg[3] = 1'b0; mask = '1; uv = '1;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      // R10: reset state
      #1;
      chk_valid("R10 in reset", 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_valid("R10 after reset", 1'b0);

      // R1 / R2: exhaustive live sweep in both monitoring modes
      for (int w = 0; w < 2; w++)
         for (int u = 0; u < 8; u++)
            for (int o = 0; o < 8; o++)
               for (int m = 0; m < 8; m++) begin
                  cfg = {2'b00, 1'b0, w[0], 2'b00};
                  uv = N'(u); ov = N'(o); mask = N'(m);
                  repeat (DS + 1) @(negedge clk);
                  chk_valid(w ? "R1 window sweep" : "R2 mask sweep",
                            live_ok(N'(u), N'(o), N'(m), w[0]));
               end

      // R3: latched sweep; live flags toggled and must not matter
      for (int l = 0; l < 2; l++)
         for (int f = 0; f < 8; f++)
            for (int m = 0; m < 8; m++) begin
               cfg = 6'b00_1000;
               uv = l ? '0 : '1; ov = '1;
               flt = N'(f); mask = N'(m);
               repeat (DS + 1) @(negedge clk);
               chk_valid("R3 latched sweep", latch_ok(N'(f), N'(m)));
            end
      flt = '1;

      // R4: exact short delay
      go_bad();
      cfg = '0; uv = '0;
      repeat (DS - 1) @(negedge clk);
      chk_valid("R4 short one edge early", 1'b0);
      @(negedge clk);
      chk_valid("R4 short on time", 1'b1);

      // R5: loss propagates after one edge
      uv[1] = 1'b1;
      @(negedge clk);
      chk_valid("R5 immediate loss", 1'b0);

      // R4: exact long delay
      go_bad();
      cfg = 6'b01_0000; uv = '0;
      repeat (DL - 1) @(negedge clk);
      chk_valid("R4 long one edge early", 1'b0);
      @(negedge clk);
      chk_valid("R4 long on time", 1'b1);

      // R6: dropout mid-count restarts
      go_bad();
      cfg = '0; uv = '0;
      repeat (10) @(negedge clk);
      uv[2] = 1'b1;
      @(negedge clk);
      uv[2] = 1'b0;
      repeat (DS - 1) @(negedge clk);
      chk_valid("R6 restart not early", 1'b0);
      @(negedge clk);
      chk_valid("R6 restart full window", 1'b1);

      // R6: dropout on the completing edge wins
      go_bad();
      uv = '0;
      repeat (DS - 1) @(negedge clk);
      uv[0] = 1'b1;
      @(negedge clk);
      chk_valid("R6 drop on final edge", 1'b0);
      uv[0] = 1'b0;
      repeat (DS - 1) @(negedge clk);
      chk_valid("R6 after final-edge drop early", 1'b0);
      @(negedge clk);
      chk_valid("R6 after final-edge drop", 1'b1);

      // R7 / R8: polarity and drive type for both validity states
      for (int v = 0; v < 2; v++) begin
         if (v == 0) go_bad();
         else begin
            uv = '0;
            repeat (DS + 1) @(negedge clk);
         end
         for (int c = 0; c < 4; c++) begin
            bit lvl;
            cfg = 6'(c);
            #1;
            lvl = v[0] ^ c[0];
            if (c[1]) chk("R8 open-drain", {pg_oe, pg_out}, {~lvl, 1'b0});
            else      chk("R7 polarity push-pull", {pg_oe, pg_out}, {1'b1, lvl});
         end
      end

      // R9: interrupt merge, combinational
      for (int k = 0; k < 16; k++) begin
         cfg = {k[0], 2'b00, k[3], 2'b00};
         int_src_n = k[1];
         uv[0] = k[2];
         ov[0] = 1'b1;
         #1;
         chk("R9 interrupt merge", {1'b0, int_n},
             {1'b0, k[1] & ~(k[0] & (k[2] | k[3]))});
      end
      int_src_n = 1'b1; ov = '0;

      // R10: reset mid-run clears state and count
      cfg = '0; uv = '0;
      repeat (DS + 1) @(negedge clk);
      chk_valid("R10 valid before reset", 1'b1);
      rst_n = 1'b0;
      #1;
      chk_valid("R10 reset clears", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (DS - 1) @(negedge clk);
      chk_valid("R10 full window after reset", 1'b0);
      @(negedge clk);
      chk_valid("R10 valid after reset window", 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule